// File: doc/BRIEF.md
# Fan PWM Generator with Rise/Fall Compare Points

This block drives a set of fan PWM pins from one shared timebase. A clock-type word picks a prescale ratio and an 8-bit period. The prescale ratio is a power-of-two stage times a doubled low stage. The period counter then steps once per prescaler tick, from 0 up to the period value. Each channel compares that counter with its own rise point and fall point to shape its pulse.

To set a partial duty, software writes the rise point as 0 and the fall point as the on-time in ticks. Setting both points equal keeps the pin high for the whole period. For 0% duty, software clears the channel enable. New compare points are held in a shadow copy and are only taken at a period boundary, so a mid-period write never produces a short pulse. A global run bit stops all counting and forces every pin low.

Top module: `fan_pwm_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every PWM pin is low.
- R2: The prescale ratio is 2^H times the low factor. H is `type_cfg[7:4]`. The low factor is 1 when L (`type_cfg[3:0]`) is 0, and 2×L otherwise. The period counter advances exactly once per ratio cycles.
- R3: The period counter runs from 0 to P (`type_cfg[15:8]`) and then returns to 0, so one PWM period lasts (P+1)×ratio clock cycles.
- R4: When rise < fall, the pin is high while the counter is at least rise and below fall. With rise 0 and fall k, that gives k×ratio high cycles per period.
- R5: When rise equals fall, the pin is high for the whole period (100% duty).
- R6: When rise > fall, the high window wraps around the period end. The pin is high while the counter is at or above rise, or below fall.
- R7: A channel whose bit in `ch_en` is 0 drives its pin low from the next clock cycle on, whatever its compare points are.
- R8: While `clk_en` is low, the prescaler and the period counter are held at 0 and all pins are low. Counting restarts from 0 on the cycle after `clk_en` returns high.
- R9: Channel 2k takes its rise point from bits [7:0] of 32-bit word k of `duty_words` and its fall point from bits [15:8]. Channel 2k+1 takes its rise point from bits [23:16] and its fall point from bits [31:24].
- R10: Compare points written while the block runs take effect only from the next counter wrap to 0. While `clk_en` is low, the points are loaded directly.
- R11: The default setting (P=0x5F, H=0, L=5) gives a ratio of 10 and a period of 960 cycles.
- R12: Each pin is a register. Its value in a cycle reflects the counter, the shadow points, `ch_en` and `clk_en` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Global run bit; low stops counting and forces pins low |
| type_cfg | input | 16 | Clock type: period [15:8], high divider [7:4], low divider [3:0] |
| ch_en | input | NUM_CH | Per-channel output enable |
| duty_words | input | 16×NUM_CH | Rise/fall points, two channels per 32-bit word |
| pwm_out | output | NUM_CH | PWM pins, one per channel |

## Verification
If the prescaler holds a wrong count, every channel's period stretches or shrinks at once. High-time and edge counts over a few periods expose it. A counter that misses its wrap makes the pins stay high or low far past (P+1)×ratio cycles. This shows within one period.

A stale or early shadow load shows up in two ways. Either a high run keeps its old length after a mid-period write, or it changes length inside the same period. Either is visible at the first boundary after the write. Gating errors on `ch_en` or `clk_en` show as a pin that is high one cycle after it was disabled.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

  // Divider field width, period field width, prescaler counter width
  localparam int DIV_W = 4;
  localparam int PER_W = 8;
  localparam int PRE_W = (2 ** DIV_W - 1) + $clog2(2 ** (DIV_W + 1));

  // Clock type word: period in [15:8], high divider in [7:4], low divider in [3:0]
  typedef struct packed {
    logic [PER_W-1:0] period;
    logic [DIV_W-1:0] hi_div;
    logic [DIV_W-1:0] lo_div;
  } clk_type_t;

  // One channel's compare pair: fall in the upper byte, rise in the lower byte
  typedef struct packed {
    logic [PER_W-1:0] fall;
    logic [PER_W-1:0] rise;
  } edge_pts_t;

  // Clock cycles per counter step
  function automatic logic [PRE_W-1:0] div_ratio(input logic [DIV_W-1:0] h,
                                                 input logic [DIV_W-1:0] l);
    logic [PRE_W-1:0] base;
    base = (l == '0) ? PRE_W'(1) : PRE_W'({l, 1'b0});
    return base << h;
  endfunction

  // Level for a given counter value and compare pair
  function automatic logic in_on_window(input logic [PER_W-1:0] c,
                                        input logic [PER_W-1:0] r,
                                        input logic [PER_W-1:0] f);
    logic lvl;
    if (r == f)     lvl = 1'b1;
    else if (r < f) lvl = (c >= r) && (c < f);
    else            lvl = (c >= r) || (c < f);
    return lvl;
  endfunction

endpackage

// File: rtl/fpg_prescaler.sv
module fpg_prescaler
  import fpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] hi_div,
  input  logic [DIV_W-1:0] lo_div,
  output logic             tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] ratio;

  assign ratio = div_ratio(hi_div, lo_div);
  // >= guards against a ratio lowered mid-count
  assign tick  = run && (pre_q >= ratio - PRE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run)   pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + PRE_W'(1);
  end

endmodule

// File: rtl/fpg_period_cnt.sv
module fpg_period_cnt
  import fpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  output logic [PER_W-1:0] cnt,
  output logic             wrap
);

  // >= guards against a period lowered below the current count
  assign wrap = tick && (cnt >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (wrap)  cnt <= '0;
    else if (tick)  cnt <= cnt + PER_W'(1);
  end

endmodule

// File: rtl/fpg_channel.sv
module fpg_channel
  import fpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ch_en,
  input  logic             load,
  input  edge_pts_t        pts_in,
  input  logic [PER_W-1:0] cnt,
  output logic             pwm
);

  edge_pts_t shadow_q;
  logic      level;

  assign level = in_on_window(cnt, shadow_q.rise, shadow_q.fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shadow_q <= '0;
    else if (load) shadow_q <= pts_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm <= 1'b0;
    else        pwm <= run && ch_en && level;
  end

endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fpg_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_en,
  input  logic [15:0]         type_cfg,
  input  logic [NUM_CH-1:0]   ch_en,
  input  logic [NUM_CH*16-1:0] duty_words,
  output logic [NUM_CH-1:0]   pwm_out
);

  localparam int PTS_W = 2 * PER_W;

  clk_type_t        cfg;
  logic             tick;
  logic             wrap;
  logic             load;
  logic [PER_W-1:0] cnt_q;

  assign cfg  = clk_type_t'(type_cfg);
  // Shadow load at each period boundary, and continuously while stopped
  assign load = wrap || !clk_en;

  fpg_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (clk_en),
    .hi_div (cfg.hi_div),
    .lo_div (cfg.lo_div),
    .tick   (tick)
  );

  fpg_period_cnt u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (clk_en),
    .tick   (tick),
    .period (cfg.period),
    .cnt    (cnt_q),
    .wrap   (wrap)
  );

  // Channel c uses bits [c*16 +: 16]; two channels per 32-bit word
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    fpg_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (clk_en),
      .ch_en  (ch_en[c]),
      .load   (load),
      .pts_in (edge_pts_t'(duty_words[c*PTS_W +: PTS_W])),
      .cnt    (cnt_q),
      .pwm    (pwm_out[c])
    );
  end

endmodule

// File: rtl/fpg_checker.sv
module fpg_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] pwm_out,
  input logic              tick,
  input logic              wrap,
  input logic [7:0]        cnt
);

  AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> (pwm_out == '0));                                     // R8

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> (cnt == 8'd0));                                       // R8

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> clk_en);                                                 // R8

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~$past(ch_en)) == '0);                                 // R7

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == 8'd0));                                          // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && tick && !wrap) |=> (cnt == 8'($past(cnt) + 8'd1)));    // R3

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !tick) |=> $stable(cnt));                              // R2

endmodule

bind fan_pwm_gen fpg_checker #(.NUM_CH(NUM_CH)) u_fpg_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clk_en  (clk_en),
  .ch_en   (ch_en),
  .pwm_out (pwm_out),
  .tick    (tick),
  .wrap    (wrap),
  .cnt     (cnt_q)
);

// File: tb/fan_pwm_gen_tb.sv
module fan_pwm_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int WATCHDOG = 200000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             clk_en;
  logic [15:0]      type_cfg;
  logic [NCH-1:0]   ch_en;
  logic [NCH*16-1:0] duty_words;
  logic [NCH-1:0]   pwm_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mism = 0;
  logic [NCH-1:0] first_act, first_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  fan_pwm_gen #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .type_cfg(type_cfg),
    .ch_en(ch_en), .duty_words(duty_words), .pwm_out(pwm_out)
  );

  // ---- reference arithmetic, written from the requirements ----
  function automatic int exp_ratio(int h, int l);
    int low;
    low = (l == 0) ? 1 : l * 2;
    return low * (1 << h);
  endfunction

  function automatic bit exp_level(int c, int r, int f);
    if (r == f) return 1'b1;
    if (r < f)  return (c >= r && c < f);
    return !(c < r && c >= f);
  endfunction

  // ---- cycle model ----
  int m_pre, m_cnt;
  int m_r [NCH];
  int m_f [NCH];
  logic [NCH-1:0] m_out;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre <= 0; m_cnt <= 0; m_out <= '0;
      for (int i = 0; i < NCH; i++) begin m_r[i] <= 0; m_f[i] <= 0; end
    end else begin
      for (int i = 0; i < NCH; i++)
        m_out[i] <= clk_en && ch_en[i] && exp_level(m_cnt, m_r[i], m_f[i]);
      if (!clk_en) begin
        m_pre <= 0; m_cnt <= 0;
        for (int i = 0; i < NCH; i++) begin
          m_r[i] <= int'(duty_words[i*16 +: 8]);
          m_f[i] <= int'(duty_words[i*16+8 +: 8]);
        end
      end else if (m_pre >= exp_ratio(int'(type_cfg[7:4]), int'(type_cfg[3:0])) - 1) begin
        m_pre <= 0;
        if (m_cnt >= int'(type_cfg[15:8])) begin
          m_cnt <= 0;
          for (int i = 0; i < NCH; i++) begin
            m_r[i] <= int'(duty_words[i*16 +: 8]);
            m_f[i] <= int'(duty_words[i*16+8 +: 8]);
          end
        end else m_cnt <= m_cnt + 1;
      end else m_pre <= m_pre + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && pwm_out !== m_out) begin
      if (mism == 0) begin first_act = pwm_out; first_exp = m_out; end
      mism++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: %0d cycles, expected at most %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---- helpers ----
  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_phase(string req, int ncyc);
    mism = 0;
    repeat (ncyc) @(negedge clk);
    checks++;
    if (mism != 0) begin
      errors++;
      $display("FAIL %s: %0d mismatching cycles, first actual %b expected %b",
               req, mism, first_act, first_exp);
    end
  endtask

  task automatic set_cfg(int p, int h, int l);
    type_cfg = {8'(p), 4'(h), 4'(l)};
  endtask

  task automatic set_pts(int ch, int r, int f);
    duty_words[ch*16 +: 16] = {8'(f), 8'(r)};
  endtask

  task automatic count_high(int ch, int ncyc, output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0; prev = pwm_out[ch];
    repeat (ncyc) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
      if (pwm_out[ch] && !prev) rises++;
      prev = pwm_out[ch];
    end
  endtask

  int hi, rs, run_len;

  initial begin
    void'($urandom(32'd7319));
    rst_n = 1'b0; clk_en = 1'b0; ch_en = '0; duty_words = '0;
    set_cfg(8'h5F, 0, 5);
    repeat (4) @(negedge clk);
    chk("R1 pins low in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pins low after reset", int'(pwm_out), 0);

    // Default clock type
    set_pts(0, 0, 8'h30); set_pts(1, 0, 0); set_pts(2, 8'h50, 8'h10); set_pts(3, 8'h20, 8'h20);
    ch_en = 4'hF; clk_en = 1'b1;
    compare_phase("R11 default timing vs model", 2000);
    count_high(0, 1920, hi, rs);
    chk("R11 default ratio 10, high cycles over 2 periods", hi, 2 * 10 * 8'h30);
    chk("R3 default rising edges over 2 periods", rs, 2);

    // Ratio 2, period 10 ticks
    set_cfg(9, 1, 0);
    set_pts(0, 0, 4); set_pts(1, 0, 0); set_pts(2, 7, 2); set_pts(3, 2, 5);
    compare_phase("R12 reconfigure vs model", 1000);
    count_high(0, 400, hi, rs);
    chk("R4 rise<fall high cycles", hi, 20 * 4 * 2);
    chk("R3 edges per 20 periods", rs, 20);
    count_high(1, 400, hi, rs);
    chk("R5 equal points full high", hi, 400);
    count_high(2, 400, hi, rs);
    chk("R6 wrapped window high cycles", hi, 20 * 5 * 2);
    count_high(3, 400, hi, rs);
    chk("R9 upper half of word 1 high cycles", hi, 20 * 3 * 2);

    // Ratio 24 (H=2, L=3), period 5 ticks
    set_cfg(4, 2, 3);
    set_pts(0, 0, 2);
    compare_phase("R2 ratio 24 vs model", 300);
    count_high(0, 240, hi, rs);
    chk("R2 ratio 24 high cycles", hi, 2 * 2 * 24);

    // Disable channel 0
    ch_en = 4'b1110;
    @(negedge clk);
    count_high(0, 240, hi, rs);
    chk("R7 disabled channel stays low", hi, 0);
    compare_phase("R7 others unaffected vs model", 240);
    ch_en = 4'hF;

    // Shadowed update: ratio 1, period 20 ticks
    set_cfg(19, 0, 0);
    set_pts(0, 0, 10);
    repeat (60) @(negedge clk);
    while (pwm_out[0]) @(negedge clk);
    while (!pwm_out[0]) @(negedge clk);
    set_pts(0, 0, 15);
    run_len = 0;
    while (pwm_out[0]) begin run_len++; @(negedge clk); end
    chk("R10 current period keeps old fall point", run_len, 10);
    while (!pwm_out[0]) @(negedge clk);
    run_len = 0;
    while (pwm_out[0]) begin run_len++; @(negedge clk); end
    chk("R10 next period uses new fall point", run_len, 15);

    // Global stop and restart
    clk_en = 1'b0;
    @(negedge clk);
    count_high(0, 48, hi, rs);
    chk("R8 stopped pins low", int'(pwm_out) + hi, 0);
    clk_en = 1'b1;
    chk("R8 pin still low on enable cycle", int'(pwm_out[0]), 0);
    @(negedge clk);
    chk("R12 pin high one cycle after restart", int'(pwm_out[0]), 1);
    compare_phase("R8 restart from zero vs model", 200);

    // Random configurations
    for (int it = 0; it < 25; it++) begin
      int p, h, l, len;
      p = 3 + int'($urandom_range(27)); h = int'($urandom_range(2)); l = int'($urandom_range(3));
      set_cfg(p, h, l);
      for (int c = 0; c < NCH; c++)
        set_pts(c, int'($urandom_range(p + 2)), int'($urandom_range(p + 2)));
      ch_en = 4'($urandom);
      len = (p + 1) * exp_ratio(h, l);
      compare_phase("R12 random config vs model", len + 5);
      set_pts(int'($urandom_range(NCH - 1)), int'($urandom_range(p)), int'($urandom_range(p)));
      compare_phase("R10 random mid-period update vs model", 2 * len + 5);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule